// File: doc/BRIEF.md
# Filtered Quadrature Position Decoder

This block turns the two phase signals of an incremental encoder, plus an optional index pulse, into a signed position count. A phase input is first brought into the clock domain and then passed through a glitch filter. The filter accepts a new level only after that level has been sampled the same way for K cycles in a row. The decoder acts on every accepted edge of either phase, so one encoder line yields four counts. The direction of each count comes from which phase leads.

Alongside the position, the block keeps two measurement registers for speed computation. The first accumulates the count change since it was last read, and a read clears it. The second captures the number of clock cycles between successive reads of the first. Software divides one by the other, or uses either alone, for fast or slow shafts. A no-motion watchdog raises a sticky alarm when no valid step has been seen for a programmable number of cycles. A change of both phases in the same filtered sample is flagged as a sticky error and not counted.

Registers are written and read through a simple word interface. The address codes are: 0 setup, 1 watchdog timeout, 2 position, 3 status, 4 difference, 5 elapsed-time hold, 6 index reload value. Reads are combinational. Side effects of a read take place at the clock edge that ends the read cycle.

Top module: `qdec_top`

## Requirements
- R1: Phase code {enc_a, enc_b} stepping forward through 00, 10, 11, 01, 00 increments the position by one per filtered edge, and the reverse order decrements it, so one full phase cycle changes the count by 4.
- R2: Each input becomes visible to the decoder only after K consecutive identical synchronized samples. A raw pulse shorter than K cycles has no effect. K is setup bits [3:0], clamped to the range 3 to 10 and read back clamped.
- R3: A filtered sample in which both phases change together leaves position and difference unchanged and sets the error flag (status bit 1, also on port err).
- R4: With a nonzero timeout T, alarm (status bit 0, also on port alarm) rises T+1 cycles after the timeout write or after the last counted step, provided no step occurs in between. T = 0 disables the alarm.
- R5: Every counted step restarts the watchdog, so steps spaced fewer than T cycles apart never raise the alarm.
- R6: The alarm and the error flag stay set until a status write with bit 0 (alarm) or bit 1 (error) set to 1.
- R7: A read of the difference register returns the net count change since the previous such read and clears it. A step counted on the clearing edge is kept.
- R8: On each difference read, the hold register captures the number of clock cycles since the previous difference read (or since reset), saturating at all ones.
- R9: When setup bit 4 is 1, a filtered rising edge of the index input loads the position with the index reload value. When the bit is 0, the index has no effect.
- R10: A write to the position register loads it, with priority over index and counting.
- R11: After reset: position 0, difference 0, alarm 0, error 0, K = 4, index disabled, timeout 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| enc_idx | input | 1 | Raw encoder index pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe (needed for read side effects) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for rd_addr, combinational |
| alarm | output | 1 | Sticky no-motion alarm |
| err | output | 1 | Sticky illegal-transition flag |

## Verification
A wrong filter count shows up within a few cycles of a short glitch: a pulse of K-1 cycles must never move the position read just after it, while a pulse of K cycles must. A wrong decode table or a lost step appears at the next position or difference read, after a random walk of a few hundred steps is compared against a bench-side count. A wrong watchdog reload or compare shows as an alarm one or more cycles early or late against a window of exactly T+1 cycles. Loss of stickiness shows at the next status read.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int KW    = 4;
    localparam int K_MIN = 3;
    localparam int K_MAX = 10;
    localparam int K_RST = 4;

    typedef enum logic [2:0] {
        RA_CFG  = 3'd0,
        RA_TMO  = 3'd1,
        RA_POS  = 3'd2,
        RA_STAT = 3'd3,
        RA_DIFF = 3'd4,
        RA_HOLD = 3'd5,
        RA_IDXV = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic a;
        logic b;
    } phase_t;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_UP   = 2'd1,
        MV_DN   = 2'd2,
        MV_BAD  = 2'd3
    } move_e;

    function automatic logic [KW-1:0] clamp_k(input logic [KW-1:0] k);
        if (k < KW'(K_MIN))      return KW'(K_MIN);
        else if (k > KW'(K_MAX)) return KW'(K_MAX);
        else                     return k;
    endfunction

    function automatic move_e decode_move(input phase_t prev, input phase_t cur);
        if (prev == cur)                            return MV_NONE;
        else if (prev.a != cur.a && prev.b != cur.b) return MV_BAD;
        else if (cur.a ^ prev.b)                    return MV_UP;
        else                                        return MV_DN;
    endfunction

endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
    parameter int N  = 3,
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  raw,
    input  logic [KW-1:0] k,
    output logic [N-1:0]  filt
);

    for (genvar gi = 0; gi < N; gi++) begin : g_ch
        logic          s1, s2, lvl;
        logic [KW-1:0] run;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1  <= 1'b0;
                s2  <= 1'b0;
                lvl <= 1'b0;
                run <= '0;
            end else begin
                s1 <= raw[gi];
                s2 <= s1;
                if (s2 == lvl) begin
                    run <= '0;
                end else if (run == k - KW'(1)) begin
                    lvl <= s2;
                    run <= '0;
                end else begin
                    run <= run + KW'(1);
                end
            end
        end

        assign filt[gi] = lvl;
    end

endmodule

// File: rtl/qdec_core.sv
module qdec_core
    import qdec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  phase_t       ph,
    input  logic         idx,
    input  logic         idx_en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] idx_val,
    input  logic         diff_clr,
    input  logic         err_clr,
    output logic [W-1:0] pos,
    output logic [W-1:0] diff,
    output move_e        mv,
    output logic         idx_hit,
    output logic         err
);

    phase_t       prev;
    logic         idx_prev;
    logic [W-1:0] delta;

    assign mv      = decode_move(prev, ph);
    assign idx_hit = idx_en & idx & ~idx_prev;

    always_comb begin
        unique case (mv)
            MV_UP:   delta = W'(1);
            MV_DN:   delta = '1;
            default: delta = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= '0;
            idx_prev <= 1'b0;
            pos      <= '0;
            diff     <= '0;
            err      <= 1'b0;
        end else begin
            prev     <= ph;
            idx_prev <= idx;
            if (ld)           pos <= ld_val;
            else if (idx_hit) pos <= idx_val;
            else              pos <= pos + delta;
            diff <= diff_clr ? delta : diff + delta;
            if (mv == MV_BAD) err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

endmodule

// File: rtl/qdec_watch.sv
module qdec_watch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         restart,
    input  logic [W-1:0] limit,
    input  logic         clr,
    input  logic         snap,
    output logic         alarm,
    output logic [W-1:0] hold
);

    logic [W-1:0] idle_cnt;
    logic [W-1:0] span;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            alarm    <= 1'b0;
            span     <= '0;
            hold     <= '0;
        end else begin
            if (step || restart)    idle_cnt <= '0;
            else if (idle_cnt != '1) idle_cnt <= idle_cnt + W'(1);

            if (limit != '0 && idle_cnt == limit) alarm <= 1'b1;
            else if (clr)                         alarm <= 1'b0;

            if (snap) begin
                hold <= span;
                span <= W'(1);
            end else if (span != '1) begin
                span <= span + W'(1);
            end
        end
    end

endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enc_a,
    input  logic         enc_b,
    input  logic         enc_idx,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic [2:0]   rd_addr,
    output logic [W-1:0] rd_data,
    output logic         alarm,
    output logic         err
);

    logic [KW-1:0] cfg_k;
    logic          idx_en;
    logic [W-1:0]  tmo;
    logic [W-1:0]  idx_val;
    logic [2:0]    filt;
    phase_t        ph;
    logic [W-1:0]  pos_q, diff_q, hold_q;
    move_e         mv;
    logic          idx_hit;
    logic          wr_cfg, wr_tmo, wr_pos, wr_stat, wr_idxv, rd_diff;
    logic          unused_bits;

    assign unused_bits = ^wr_data[W-1:5];

    assign wr_cfg  = wr_en && wr_addr == RA_CFG;
    assign wr_tmo  = wr_en && wr_addr == RA_TMO;
    assign wr_pos  = wr_en && wr_addr == RA_POS;
    assign wr_stat = wr_en && wr_addr == RA_STAT;
    assign wr_idxv = wr_en && wr_addr == RA_IDXV;
    assign rd_diff = rd_en && rd_addr == RA_DIFF;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_k   <= KW'(K_RST);
            idx_en  <= 1'b0;
            tmo     <= '0;
            idx_val <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_k  <= clamp_k(wr_data[KW-1:0]);
                idx_en <= wr_data[4];
            end
            if (wr_tmo)  tmo     <= wr_data;
            if (wr_idxv) idx_val <= wr_data;
        end
    end

    qdec_filter #(.N(3), .KW(KW)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .raw  ({enc_idx, enc_b, enc_a}),
        .k    (cfg_k),
        .filt (filt)
    );

    assign ph.a = filt[0];
    assign ph.b = filt[1];

    qdec_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .idx      (filt[2]),
        .idx_en   (idx_en),
        .ld       (wr_pos),
        .ld_val   (wr_data),
        .idx_val  (idx_val),
        .diff_clr (rd_diff),
        .err_clr  (wr_stat && wr_data[1]),
        .pos      (pos_q),
        .diff     (diff_q),
        .mv       (mv),
        .idx_hit  (idx_hit),
        .err      (err)
    );

    qdec_watch #(.W(W)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .step    (mv == MV_UP || mv == MV_DN),
        .restart (wr_tmo),
        .limit   (tmo),
        .clr     (wr_stat && wr_data[0]),
        .snap    (rd_diff),
        .alarm   (alarm),
        .hold    (hold_q)
    );

    always_comb begin
        case (rd_addr)
            RA_CFG:  rd_data = {{(W-5){1'b0}}, idx_en, cfg_k};
            RA_TMO:  rd_data = tmo;
            RA_POS:  rd_data = pos_q;
            RA_STAT: rd_data = {{(W-2){1'b0}}, err, alarm};
            RA_DIFF: rd_data = diff_q;
            RA_HOLD: rd_data = hold_q;
            RA_IDXV: rd_data = idx_val;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/qdec_chk.sv
module qdec_chk
    import qdec_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pos,
    input logic [W-1:0] diff,
    input move_e        mv,
    input logic         idx_hit,
    input logic         alarm,
    input logic         err,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic         rd_en,
    input logic [2:0]   rd_addr
);

    logic ld_pos, clr_alarm, clr_err, rd_diff;
    assign ld_pos    = wr_en && wr_addr == RA_POS;
    assign clr_alarm = wr_en && wr_addr == RA_STAT && wr_data[0];
    assign clr_err   = wr_en && wr_addr == RA_STAT && wr_data[1];
    assign rd_diff   = rd_en && rd_addr == RA_DIFF;

    p_unit_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!ld_pos && !idx_hit) |=>
            (pos == $past(pos) || pos == $past(pos) + W'(1) || pos == $past(pos) - W'(1)));

    p_bad_no_count_r3: assert property (@(posedge clk) disable iff (rst)
        (mv == MV_BAD && !ld_pos && !idx_hit) |=> (pos == $past(pos)));

    p_bad_sets_err_r3: assert property (@(posedge clk) disable iff (rst)
        (mv == MV_BAD) |=> err);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (err && !clr_err) |=> err);

    p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (alarm && !clr_alarm) |=> alarm);

    p_diff_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_diff && (mv == MV_NONE || mv == MV_BAD)) |=> (diff == '0));

endmodule

bind qdec_top qdec_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pos     (pos_q),
    .diff    (diff_q),
    .mv      (mv),
    .idx_hit (idx_hit),
    .alarm   (alarm),
    .err     (err),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr)
);

// File: tb/sim_qdec_top.sv
`timescale 1ns/1ps
module sim_qdec_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         alarm, err;

    int n_chk = 0;
    int n_fail = 0;
    int ph = 0;
    logic [W-1:0] exp_pos = '0;
    logic [W-1:0] exp_diff = '0;
    logic [W-1:0] v;

    always #4 clk = ~clk;

    qdec_top #(.W(W)) u0 (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .alarm(alarm), .err(err)
    );

    function automatic logic [1:0] code_of(input int i);
        case (i & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic move(input int dir, input int hold);
        ph = ph + dir;
        {enc_a, enc_b} = code_of(ph);
        exp_pos  = exp_pos + W'(dir);
        exp_diff = exp_diff + W'(dir);
        repeat (hold) @(negedge clk);
    endtask

    task automatic glitch_a(input int w, input bit accept, input string req);
        logic [1:0] flip;
        logic [W-1:0] d, e;
        flip = code_of(ph) ^ 2'b10;
        e = exp_pos;
        if (accept) e = (flip == code_of(ph + 1)) ? exp_pos + W'(1) : exp_pos - W'(1);
        enc_a = ~enc_a;
        repeat (w) @(negedge clk);
        enc_a = ~enc_a;
        repeat (4) @(negedge clk);
        rd(3'd2, d);
        check(req, d, e);
        repeat (30) @(negedge clk);
        rd(3'd2, d);
        check(req, d, exp_pos);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        rd(3'd2, v); check("R11 pos", v, 0);
        rd(3'd4, v); check("R11 diff", v, 0);
        rd(3'd3, v); check("R11 status", v, 0);
        rd(3'd0, v); check("R11 setup", v, 4);
        rd(3'd1, v); check("R11 timeout", v, 0);

        // R1 forward two full cycles, reverse one
        for (int i = 0; i < 8; i++) move(1, 20);
        rd(3'd2, v); check("R1 forward x4", v, 8);
        for (int i = 0; i < 4; i++) move(-1, 20);
        rd(3'd2, v); check("R1 reverse", v, 4);

        // R7 difference read-and-clear
        rd(3'd4, v); check("R7 diff", v, 4);
        rd(3'd4, v); check("R7 diff cleared", v, 0);
        exp_diff = '0;

        // R8 elapsed hold: reads 37 cycles apart
        rd(3'd4, v);
        repeat (36) @(negedge clk);
        rd(3'd4, v);
        rd(3'd5, v); check("R8 hold", v, 37);

        // R2 filter with K=5
        wr(3'd0, 16'd5);
        glitch_a(4, 1'b0, "R2 short pulse ignored");
        glitch_a(5, 1'b1, "R2 K-long pulse accepted");
        wr(3'd0, 16'd1);
        rd(3'd0, v); check("R2 clamp low", v, 3);
        glitch_a(2, 1'b0, "R2 short pulse K=3");
        glitch_a(3, 1'b1, "R2 pulse K=3");
        wr(3'd0, 16'd15);
        rd(3'd0, v); check("R2 clamp high", v, 10);
        wr(3'd0, 16'd4);

        // R3 illegal double change
        ph = ph + 2;
        {enc_a, enc_b} = code_of(ph);
        repeat (20) @(negedge clk);
        rd(3'd2, v); check("R3 pos unchanged", v, exp_pos);
        rd(3'd3, v); check("R3 err flag", v & 16'h2, 16'h2);
        check("R3 err port", W'(err), 1);
        move(1, 20);
        rd(3'd3, v); check("R6 err sticky", v & 16'h2, 16'h2);
        wr(3'd3, 16'h2);
        rd(3'd3, v); check("R6 err cleared", v & 16'h2, 0);
        rd(3'd4, v); check("R3 diff", v, exp_diff);
        exp_diff = '0;

        // R10 position load
        wr(3'd2, 16'h1234); exp_pos = 16'h1234;
        rd(3'd2, v); check("R10 load", v, 16'h1234);

        // R9 index
        wr(3'd6, 16'd100);
        wr(3'd0, 16'h0014);
        enc_idx = 1'b1; repeat (12) @(negedge clk); enc_idx = 1'b0;
        repeat (20) @(negedge clk);
        rd(3'd2, v); check("R9 index load", v, 100);
        wr(3'd0, 16'h0004);
        wr(3'd2, 16'd7); exp_pos = 16'd7;
        enc_idx = 1'b1; repeat (12) @(negedge clk); enc_idx = 1'b0;
        repeat (20) @(negedge clk);
        rd(3'd2, v); check("R9 index disabled", v, 7);

        // R4 watchdog timing, T=40
        wr(3'd3, 16'h1);
        wr(3'd1, 16'd40);
        repeat (39) @(negedge clk);
        check("R4 alarm not early", W'(alarm), 0);
        repeat (3) @(negedge clk);
        check("R4 alarm on time", W'(alarm), 1);
        repeat (20) @(negedge clk);
        rd(3'd3, v); check("R6 alarm sticky", v & 16'h1, 1);
        wr(3'd3, 16'h1);
        check("R6 alarm cleared", W'(alarm), 0);

        // R5 steps restart the watchdog
        wr(3'd1, 16'd40);
        for (int i = 0; i < 6; i++) move(1, 25);
        check("R5 no alarm while moving", W'(alarm), 0);
        repeat (50) @(negedge clk);
        check("R5 alarm after idle", W'(alarm), 1);

        // R4 disable
        wr(3'd1, 16'd0);
        wr(3'd3, 16'h1);
        repeat (100) @(negedge clk);
        check("R4 disabled", W'(alarm), 0);

        // random walk, R1 and R7 against bench count
        rd(3'd4, v);
        exp_diff = '0;
        wr(3'd0, 16'($urandom_range(10, 3)));
        for (int i = 0; i < 300; i++) begin
            move(($urandom_range(1, 0) == 1) ? 1 : -1, $urandom_range(40, 14));
            if (i % 75 == 74) begin
                repeat (16) @(negedge clk);
                rd(3'd2, v); check("R1 random pos", v, exp_pos);
            end
        end
        repeat (20) @(negedge clk);
        rd(3'd4, v); check("R7 random diff", v, exp_diff);
        rd(3'd2, v); check("R1 random final", v, exp_pos);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule